// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block manages a small auxiliary page of bytes that sits next to the main memory array of a two-wire serial memory. The bus front end decodes start and stop conditions, the device-select byte, the two address bytes, the data bytes and read-byte requests, and presents each as a one-cycle strobe. The controller reacts only to device selects that carry its own type nibble. A write-type command does one of two things, chosen by one address bit. It either stages bytes into the page with wrap at the page edge, or it arms a one-time lock that makes the page permanently read-only.

Staged bytes reach the page only when a stop ends the command. The stop starts a programming cycle of fixed length, and during that cycle every strobe is ignored. A start that arrives before the stop throws the staged command away. The lock state is visible to software through the data-byte acknowledge. A header with one data byte, followed by a start and a stop, probes the state without changing anything. Reads use the usual dummy-write-then-read sequence, and a sequential read wraps inside the page.

Top module: `idpg_ctrl`

## Requirements
- R1: A device select whose type nibble is not 4'b1011 engages nothing until the next start: its data bytes give ack_vld_o=0 and ack_o=0, and no programming cycle follows its stop.
- R2: With the page-select bit (address bit 10, bit 2 of the first address byte) at 0, the low 5 bits of the second address byte set the byte offset and all other address bits are ignored. Each data byte gives ack_vld_o=1 and ack_o=1 one cycle after its strobe, and the bytes land in the page when the programming cycle ends.
- R3: The write offset wraps from 31 to 0 and never leaves the page. A byte sent later overwrites an earlier byte at the same offset.
- R4: A stop that ends a write with at least one accepted byte holds busy_o high for exactly PROG_CYCLES cycles, starting in the cycle after the stop. While busy_o is high, every strobe is ignored. A stop after zero accepted bytes starts no cycle.
- R5: A start that arrives before the stop discards the staged bytes, and the page is left unchanged.
- R6: With the page-select bit at 1, the other address bits are ignored. A single data byte with bit 1 set is acknowledged. The following stop runs one programming cycle, and locked_o rises in the cycle in which busy_o falls.
- R7: A lock command whose data byte has bit 1 clear is acknowledged, starts no programming cycle, and leaves locked_o at 0.
- R8: A second data byte inside a lock command gives ack_vld_o=1 and ack_o=0, and it cancels the lock. The stop then starts no cycle.
- R9: Once locked_o is 1, it stays 1 until reset. Data bytes of any later write or lock command give ack_vld_o=1 and ack_o=0, the page stays unchanged, and the stop starts no cycle.
- R10: A probe made of a write header, one data byte, a start and a stop returns ack_o=1 when unlocked and ack_o=0 when locked. It starts no cycle and leaves the page unchanged.
- R11: A read select (type 4'b1011, read bit 1) returns the byte at the current offset on rd_data_o one cycle after each rd_stb_i, then advances the offset modulo 32. A dummy write header sets that offset.
- R12: After a write, the offset points one past the last accepted byte (modulo 32), so a read with no address continues from there.
- R13: After reset, locked_o=0, busy_o=0, ack_vld_o=0, ack_o=0, rd_data_o=0, and every page byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| start_i | input | 1 | Bus start condition seen |
| stop_i | input | 1 | Bus stop condition seen |
| dev_stb_i | input | 1 | Device-select byte received |
| dev_type_i | input | 4 | Type nibble of the device-select byte |
| dev_rd_i | input | 1 | Read/write bit of the device-select byte (1 = read) |
| addr_stb_i | input | 1 | Address byte received |
| addr_byte_i | input | 8 | Address byte value (first strobe high byte, second low byte) |
| data_stb_i | input | 1 | Data byte received from the host |
| data_byte_i | input | 8 | Data byte value |
| ack_vld_o | output | 1 | ack_o carries this block's decision for the last data byte |
| ack_o | output | 1 | 1 = acknowledge the data byte, 0 = no acknowledge |
| rd_stb_i | input | 1 | Host requests the next read byte |
| rd_data_o | output | 8 | Read byte |
| busy_o | output | 1 | Programming cycle in progress |
| locked_o | output | 1 | Page is permanently read-only |

## Verification
The acknowledge decision and each read byte are due one cycle after their strobe. Strobes are raised on a falling edge, and the result is sampled on the next falling edge, after exactly one rising edge has registered it. busy_o is due in the cycle after the stop, so the bench counts falling edges while it stays high and compares the count with PROG_CYCLES (or zero). Page contents and locked_o change at the rising edge where busy_o falls, so they are read back only after that count ends.

// File: rtl/idpg_pkg.sv
package idpg_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // waiting for a device select
    S_AHI,    // expecting the high address byte
    S_ALO,    // expecting the low address byte
    S_WDAT,   // page write data phase
    S_LOCK,   // lock command, first data byte expected
    S_LDONE,  // lock command, data byte already taken
    S_READ,   // read data phase
    S_SKIP    // not addressed to this page, wait for start
  } idpg_st_e;

  // Next byte offset inside a page of 'size' bytes.
  function automatic int unsigned wrap_next(input int unsigned off, input int unsigned size);
    return (off + 1) % size;
  endfunction

  // Extract a single bit of a byte by position, position given as an integer.
  function automatic logic bit_at(input logic [7:0] b, input int unsigned pos);
    logic [7:0] sh;
    sh = b >> pos;
    return sh[0];
  endfunction

endpackage

// File: rtl/idpg_cmd.sv
module idpg_cmd
  import idpg_pkg::*;
#(
  parameter int          PAGE_BYTES = 32,
  parameter logic [3:0]  ID_TYPE    = 4'b1011,
  parameter int unsigned SEL_BIT    = 10,
  parameter int unsigned LOCK_BIT   = 1,
  localparam int         OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             locked_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             dev_stb_i,
  input  logic [3:0]       dev_type_i,
  input  logic             dev_rd_i,
  input  logic             addr_stb_i,
  input  logic [7:0]       addr_byte_i,
  input  logic             data_stb_i,
  input  logic [7:0]       data_byte_i,
  input  logic             rd_stb_i,
  output logic             ack_vld_o,
  output logic             ack_o,
  output logic             stage_en_o,
  output logic [OFF_W-1:0] stage_off_o,
  output logic [7:0]       stage_data_o,
  output logic             clr_pend_o,
  output logic             rd_en_o,
  output logic [OFF_W-1:0] rd_off_o,
  output logic             go_wr_o,
  output logic             go_lock_o
);

  idpg_st_e         st_q, st_d;
  logic [OFF_W-1:0] ptr_q, ptr_d;
  logic             sel_q, sel_d;
  logic             arm_q, arm_d;
  logic             any_q, any_d;
  logic             ack_vld_d, ack_d;
  logic [OFF_W-1:0] ptr_inc;

  assign ptr_inc      = OFF_W'(wrap_next(int'(ptr_q), PAGE_BYTES));
  assign stage_off_o  = ptr_q;
  assign stage_data_o = data_byte_i;
  assign rd_off_o     = ptr_q;

  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    sel_d      = sel_q;
    arm_d      = arm_q;
    any_d      = any_q;
    ack_vld_d  = 1'b0;
    ack_d      = 1'b0;
    stage_en_o = 1'b0;
    rd_en_o    = 1'b0;
    go_wr_o    = 1'b0;
    go_lock_o  = 1'b0;
    clr_pend_o = 1'b0;
    if (!busy_i) begin
      if (start_i) begin
        st_d       = S_IDLE;
        arm_d      = 1'b0;
        any_d      = 1'b0;
        clr_pend_o = 1'b1;
      end else if (stop_i) begin
        go_wr_o   = (st_q == S_WDAT) && any_q;
        go_lock_o = (st_q == S_LDONE) && arm_q;
        st_d      = S_IDLE;
        arm_d     = 1'b0;
        any_d     = 1'b0;
      end else if (dev_stb_i) begin
        if (dev_type_i == ID_TYPE) st_d = dev_rd_i ? S_READ : S_AHI;
        else                       st_d = S_SKIP;
      end else if (addr_stb_i) begin
        case (st_q)
          S_AHI: begin
            sel_d = bit_at(addr_byte_i, SEL_BIT - 8);
            st_d  = S_ALO;
          end
          S_ALO: begin
            st_d = sel_q ? S_LOCK : S_WDAT;
            if (!sel_q) ptr_d = addr_byte_i[OFF_W-1:0];
          end
          default: ;
        endcase
      end else if (data_stb_i) begin
        case (st_q)
          S_WDAT: begin
            ack_vld_d = 1'b1;
            ack_d     = !locked_i;
            if (!locked_i) begin
              stage_en_o = 1'b1;
              ptr_d      = ptr_inc;
              any_d      = 1'b1;
            end
          end
          S_LOCK: begin
            ack_vld_d = 1'b1;
            ack_d     = !locked_i;
            arm_d     = !locked_i && bit_at(data_byte_i, LOCK_BIT);
            st_d      = S_LDONE;
          end
          S_LDONE: begin
            ack_vld_d = 1'b1;
            ack_d     = 1'b0;
            arm_d     = 1'b0;
            st_d      = S_SKIP;
          end
          default: ;
        endcase
      end else if (rd_stb_i && st_q == S_READ) begin
        rd_en_o = 1'b1;
        ptr_d   = ptr_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      ptr_q     <= '0;
      sel_q     <= 1'b0;
      arm_q     <= 1'b0;
      any_q     <= 1'b0;
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      st_q      <= st_d;
      ptr_q     <= ptr_d;
      sel_q     <= sel_d;
      arm_q     <= arm_d;
      any_q     <= any_d;
      ack_vld_o <= ack_vld_d;
      ack_o     <= ack_d;
    end
  end

  // R4
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !(stage_en_o || rd_en_o || go_wr_o || go_lock_o));

  // R9
  locked_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb_i && locked_i && !busy_i) |=> !ack_o);

  // R1
  foreign_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_stb_i && !busy_i && !start_i && !stop_i && dev_type_i != ID_TYPE) |=> st_q == S_SKIP);

endmodule

// File: rtl/idpg_prog.sv
module idpg_prog #(
  parameter int PROG_CYCLES = 20,
  localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_wr_i,
  input  logic go_lock_i,
  output logic busy_o,
  output logic commit_o,
  output logic locked_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             kind_lock_q;
  logic             lock_q;
  logic             done;

  assign done     = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;
  assign commit_o = done && !kind_lock_q;
  assign locked_o = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      kind_lock_q <= 1'b0;
      lock_q      <= 1'b0;
    end else if (done) begin
      busy_q <= 1'b0;
      if (kind_lock_q) lock_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (go_wr_i || go_lock_i) begin
      busy_q      <= 1'b1;
      cnt_q       <= CNT_W'(PROG_CYCLES - 1);
      kind_lock_q <= go_lock_i;
    end
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cnt_q) == '0);

  // R6
  lock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(kind_lock_q && busy_q));

endmodule

// File: rtl/idpg_store.sv
module idpg_store #(
  parameter int  PAGE_BYTES = 32,
  parameter int  DATA_W     = 8,
  localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_en_i,
  input  logic [OFF_W-1:0]  stage_off_i,
  input  logic [DATA_W-1:0] stage_data_i,
  input  logic              clr_pend_i,
  input  logic              commit_i,
  input  logic              rd_en_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0]            page_q [PAGE_BYTES];
  logic [DATA_W-1:0]            pend_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]        mask_q;
  logic [PAGE_BYTES*DATA_W-1:0] page_flat;

  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
      assign page_flat[g*DATA_W +: DATA_W] = page_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        page_q[i] <= '0;
        pend_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (commit_i && mask_q[i]) page_q[i] <= pend_q[i];
      end
      if (stage_en_i) pend_q[stage_off_i] <= stage_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      mask_q <= '0;
    else if (clr_pend_i || commit_i) mask_q <= '0;
    else if (stage_en_i)             mask_q[stage_off_i] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= page_q[rd_off_i];
  end

  // R9
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(page_flat));

  // R2
  commit_staged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> (mask_q != '0));

endmodule

// File: rtl/idpg_ctrl.sv
module idpg_ctrl #(
  parameter int          PAGE_BYTES  = 32,
  parameter int          PROG_CYCLES = 20,
  parameter logic [3:0]  ID_TYPE     = 4'b1011,
  parameter int unsigned SEL_BIT     = 10,
  parameter int unsigned LOCK_BIT    = 1,
  localparam int         OFF_W       = $clog2(PAGE_BYTES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       dev_stb_i,
  input  logic [3:0] dev_type_i,
  input  logic       dev_rd_i,
  input  logic       addr_stb_i,
  input  logic [7:0] addr_byte_i,
  input  logic       data_stb_i,
  input  logic [7:0] data_byte_i,
  output logic       ack_vld_o,
  output logic       ack_o,
  input  logic       rd_stb_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic       locked_o
);

  logic             stage_en, clr_pend, rd_en, go_wr, go_lock, commit;
  logic [OFF_W-1:0] stage_off, rd_off;
  logic [7:0]       stage_data;

  idpg_cmd #(
    .PAGE_BYTES(PAGE_BYTES), .ID_TYPE(ID_TYPE), .SEL_BIT(SEL_BIT), .LOCK_BIT(LOCK_BIT)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_o), .locked_i(locked_o),
    .start_i(start_i), .stop_i(stop_i),
    .dev_stb_i(dev_stb_i), .dev_type_i(dev_type_i), .dev_rd_i(dev_rd_i),
    .addr_stb_i(addr_stb_i), .addr_byte_i(addr_byte_i),
    .data_stb_i(data_stb_i), .data_byte_i(data_byte_i), .rd_stb_i(rd_stb_i),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o),
    .stage_en_o(stage_en), .stage_off_o(stage_off), .stage_data_o(stage_data),
    .clr_pend_o(clr_pend), .rd_en_o(rd_en), .rd_off_o(rd_off),
    .go_wr_o(go_wr), .go_lock_o(go_lock)
  );

  idpg_prog #(.PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .go_wr_i(go_wr), .go_lock_i(go_lock),
    .busy_o(busy_o), .commit_o(commit), .locked_o(locked_o)
  );

  idpg_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_store (
    .clk(clk), .rst_n(rst_n),
    .stage_en_i(stage_en), .stage_off_i(stage_off), .stage_data_i(stage_data),
    .clr_pend_i(clr_pend), .commit_i(commit),
    .rd_en_i(rd_en), .rd_off_i(rd_off), .rd_data_o(rd_data_o)
  );

endmodule

// File: tb/sim_idpg_ctrl.sv
module sim_idpg_ctrl;

  localparam int         PROG = 20;
  localparam logic [3:0] IDT  = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, dev_stb_i = 0, dev_rd_i = 0;
  logic addr_stb_i = 0, data_stb_i = 0, rd_stb_i = 0;
  logic [3:0] dev_type_i = '0;
  logic [7:0] addr_byte_i = '0, data_byte_i = '0;
  logic ack_vld_o, ack_o, busy_o, locked_o;
  logic [7:0] rd_data_o;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] mpage [32];
  logic [7:0] stg [32];
  logic       mlock = 1'b0;
  int         mptr = 0;

  always #5 clk = ~clk;

  idpg_ctrl #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .dev_stb_i(dev_stb_i), .dev_type_i(dev_type_i), .dev_rd_i(dev_rd_i),
    .addr_stb_i(addr_stb_i), .addr_byte_i(addr_byte_i),
    .data_stb_i(data_stb_i), .data_byte_i(data_byte_i),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .rd_stb_i(rd_stb_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o), .locked_o(locked_o)
  );

  function automatic int bump(input int o);
    if (o == 31) return 0;
    return o + 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic pulse_stop(input int exp_busy, input string tag);
    int n = 0;
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
    chk(tag, n, exp_busy);
  endtask

  task automatic send_dev(input logic [3:0] t, input logic rd);
    @(negedge clk); dev_stb_i = 1; dev_type_i = t; dev_rd_i = rd;
    @(negedge clk); dev_stb_i = 0;
  endtask

  task automatic send_addr(input logic [7:0] b);
    @(negedge clk); addr_stb_i = 1; addr_byte_i = b; @(negedge clk); addr_stb_i = 0;
  endtask

  task automatic send_data(input logic [7:0] b, input logic ev, input logic ea, input string tag);
    @(negedge clk); data_stb_i = 1; data_byte_i = b;
    @(negedge clk);
    chk({tag, " ack_vld"}, int'(ack_vld_o), int'(ev));
    chk({tag, " ack"}, int'(ack_o), int'(ea));
    data_stb_i = 0;
  endtask

  task automatic read_byte(input string tag);
    @(negedge clk); rd_stb_i = 1; @(negedge clk);
    chk(tag, int'(rd_data_o), int'(mpage[mptr]));
    rd_stb_i = 0;
    mptr = bump(mptr);
  endtask

  task automatic hdr(input logic [3:0] t, input logic [7:0] hi, input logic [7:0] lo);
    pulse_start(); send_dev(t, 1'b0); send_addr(hi); send_addr(lo);
    if (t == IDT && hi[2] == 1'b0) mptr = int'(lo[4:0]);
  endtask

  task automatic rd_check(input logic [7:0] lo, input int n, input string tag);
    hdr(IDT, 8'(($urandom & 8'hFB)), lo);
    pulse_start(); send_dev(IDT, 1'b1);
    for (int k = 0; k < n; k++) read_byte(tag);
    pulse_stop(0, {tag, " read busy"});
  endtask

  task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input int n, input string tag);
    logic [7:0] b;
    hdr(IDT, hi, lo);
    stg = mpage;
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      send_data(b, 1'b1, 1'b1, tag);
      stg[mptr] = b;
      mptr = bump(mptr);
    end
    pulse_stop(PROG, {tag, " busy"});
    mpage = stg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    for (int i = 0; i < 32; i++) mpage[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 locked", int'(locked_o), 0);
    chk("R13 busy", int'(busy_o), 0);
    chk("R13 ack_vld", int'(ack_vld_o), 0);
    chk("R13 ack", int'(ack_o), 0);
    chk("R13 rd_data", int'(rd_data_o), 0);
    rd_check(8'h00, 32, "R13 page zero");

    // R2 upper address bits ignored, offset from low 5 bits
    do_write(8'hF8, 8'hE5, 3, "R2");
    rd_check(8'h05, 3, "R2 readback");

    // R3 wrap at the page edge
    do_write(8'h00, 8'h1E, 34, "R3");
    rd_check(8'h00, 32, "R3 readback");

    // R12 current offset after a write
    do_write(8'h01, 8'h0A, 4, "R12 write");
    pulse_start(); send_dev(IDT, 1'b1);
    read_byte("R12 current read");
    read_byte("R12 current read");
    pulse_stop(0, "R12 busy");

    // R11 sequential read wraps inside the page
    rd_check(8'h1C, 8, "R11 wrap read");

    // R5 start discards staged bytes
    hdr(IDT, 8'h00, 8'h10);
    send_data(8'hAA, 1, 1, "R5"); mptr = bump(mptr);
    send_data(8'hBB, 1, 1, "R5"); mptr = bump(mptr);
    pulse_start();
    pulse_stop(0, "R5 busy");
    rd_check(8'h10, 2, "R5 unchanged");

    // R1 foreign type nibble
    hdr(4'b1010, 8'h00, 8'h03);
    send_data(8'h77, 0, 0, "R1");
    pulse_stop(0, "R1 busy");
    rd_check(8'h03, 1, "R1 unchanged");

    // R10 probe while unlocked
    hdr(IDT, 8'h00, 8'h07);
    send_data(8'h99, 1, 1, "R10 unlocked probe"); mptr = bump(mptr);
    pulse_start();
    pulse_stop(0, "R10 busy");
    rd_check(8'h07, 1, "R10 unchanged");

    // R7 lock byte with bit 1 clear
    hdr(IDT, 8'h04, 8'h00);
    send_data(8'hFD, 1, 1, "R7");
    pulse_stop(0, "R7 busy");
    chk("R7 locked", int'(locked_o), 0);

    // R8 second data byte in a lock command
    hdr(IDT, 8'h0C, 8'h55);
    send_data(8'h02, 1, 1, "R8 first");
    send_data(8'h02, 1, 0, "R8 second");
    pulse_stop(0, "R8 busy");
    chk("R8 locked", int'(locked_o), 0);

    // R4 strobes ignored during programming
    hdr(IDT, 8'h00, 8'h08);
    send_data(8'h5A, 1, 1, "R4");
    stg = mpage; stg[8] = 8'h5A; mptr = bump(mptr);
    @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
    chk("R4 busy after stop", int'(busy_o), 1);
    pulse_start(); send_dev(IDT, 1'b0); send_addr(8'h00); send_addr(8'h00);
    send_data(8'hEE, 0, 0, "R4 during busy");
    while (busy_o) @(negedge clk);
    mpage = stg;
    pulse_stop(0, "R4 ignored stop");
    rd_check(8'h00, 10, "R4 readback");

    // R2 R3 R11 random traffic
    for (int it = 0; it < 16; it++) begin
      do_write(8'(($urandom & 8'hFB)), 8'($urandom), 1 + int'($urandom % 40), "R2 rand");
      rd_check(8'($urandom), 1 + int'($urandom % 40), "R11 rand");
    end

    // R6 lock commit
    hdr(IDT, 8'hFF, 8'hFF);
    send_data(8'h02, 1, 1, "R6");
    pulse_stop(PROG, "R6 busy");
    chk("R6 locked", int'(locked_o), 1);
    mlock = 1'b1;

    // R9 writes refused when locked
    hdr(IDT, 8'h00, 8'h02);
    send_data(8'h11, 1, 0, "R9 data");
    send_data(8'h22, 1, 0, "R9 data");
    pulse_stop(0, "R9 busy");
    rd_check(8'h00, 32, "R9 unchanged");
    hdr(IDT, 8'h04, 8'h00);
    send_data(8'hFF, 1, 0, "R9 relock");
    pulse_stop(0, "R9 relock busy");
    chk("R9 sticky", int'(locked_o), 1);

    // R10 probe while locked
    hdr(IDT, 8'h00, 8'h04);
    send_data(8'h33, 1, 0, "R10 locked probe");
    pulse_start();
    pulse_stop(0, "R10 locked busy");
    chk("R10 still locked", int'(locked_o), int'(mlock));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule